// File: doc/BRIEF.md
# Lane Alignment Marker Sequence Checker

This block sits in the decode path that turns 513B code groups back into 66B blocks. Each cycle it may accept one group of eight decoded 66B rows. For each row the upstream de-mapper reports whether the row is a lane alignment marker, and if so which lane index it carries. The checker keeps a running position counter that predicts where marker groups must fall in the stream of 66B blocks. On an interface with `LANES` physical lanes, a marker group is one marker for each lane, in rising lane order. The next marker group starts after `GAP * LANES` further non-marker blocks. The stream therefore repeats every `(GAP + 1) * LANES` blocks.

The counter has no known phase out of reset. It starts on the first lane-0 marker it sees, and no group is checked before that point. From then on, any row that disagrees with the prediction marks the whole group as corrupt. A row disagrees if it carries a marker where none is due, lacks a marker where one is due, or carries the wrong lane index. A corrupt group is sent on as eight error control blocks, and a pass/fail flag comes out alongside it. Groups that agree with the prediction pass through untouched. The result appears one clock after the group is accepted.

Top module: `lam_seq_check`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and `out_fail` are 0.
- R2: Until the counter has locked, every valid group comes out with `out_fail` = 0 and its blocks unchanged, whatever its marker flags and lane indices are.
- R3: The counter locks on the first row, in row order, that has `in_mark` set and lane index 0. That row becomes stream position 0, and the next row in order is position 1. The group that holds it is not checked and comes out as passing.
- R4: Once locked, stream positions 0 to `LANES-1` of every period must carry a marker whose lane index equals the position. All other positions must carry no marker. The period is `(GAP+1)*LANES` blocks. Row 0 of a group is the earliest block and row 7 the latest.
- R5: A locked group in which an expected marker is absent is flagged as failing.
- R6: A locked group with a marker at a position where no marker is due is flagged as failing.
- R7: A locked group with a marker at an expected position, but carrying a lane index that differs from that position, is flagged as failing.
- R8: Each of the eight 66-bit blocks of a failing group is replaced by an error block. Its bits [1:0] are 2'b01, bits [9:2] are 8'h1E, and each 7-bit field at bits [10+7k +: 7] (k = 0..7) is 7'h1E.
- R9: `out_valid` equals `in_valid` one cycle earlier. A passing group's `out_blk` equals its `in_blk` from that cycle.
- R10: A cycle with `in_valid` = 0 does not move the counter or the lock state.
- R11: After a failing group the counter keeps advancing by eight per valid group with no resynchronisation, so later well-formed groups pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group of eight rows is offered this cycle |
| in_mark | input | 8 | Per-row marker flag, bit i for row i |
| in_lane | input | 8*LANE_W | Per-row lane index, row i at bits [i*LANE_W +: LANE_W] |
| in_blk | input | 528 | Eight 66-bit blocks, row i at bits [i*66 +: 66] |
| out_valid | output | 1 | Registered group valid |
| out_fail | output | 1 | Registered group failed the sequence check |
| out_blk | output | 528 | Forwarded or error-substituted blocks |

## Verification
The embedded assertions assume that `in_valid` is never unknown once reset is released. They also assume that one period, `(GAP+1)*LANES`, is at least eight blocks, so that a position stepped across a group wraps at most once. The bench holds `in_valid` low throughout reset and drives known values on every cycle. It sets `LANES` = 5 and `GAP` = 7, which gives a 40-block period. That short period lets many periods, lane orderings and group phases pass in a short run while staying well above the eight-block minimum.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam int ROWS  = 8;
    localparam int BLK_W = 66;

    typedef logic [BLK_W-1:0] blk_t;

    // control sync header, type byte 0x1E, then eight 7-bit error characters
    function automatic blk_t err_block();
        blk_t b;
        b       = '0;
        b[1:0]  = 2'b01;
        b[9:2]  = 8'h1E;
        for (int k = 0; k < 8; k++) begin
            b[10 + 7*k +: 7] = 7'h1E;
        end
        return b;
    endfunction

endpackage

// File: rtl/lam_row_check.sv
module lam_row_check #(
    parameter int LANES    = 4,
    parameter int PERIOD   = 65536,
    parameter int PERIOD_W = 17,
    parameter int LANE_W   = 2
) (
    input  logic [PERIOD_W-1:0]            pos,
    input  logic [lam_pkg::ROWS-1:0]        mark,
    input  logic [lam_pkg::ROWS*LANE_W-1:0] lane,
    output logic [lam_pkg::ROWS-1:0]        row_err
);
    import lam_pkg::*;

    localparam logic [PERIOD_W:0] PERIOD_X = (PERIOD_W+1)'(PERIOD);
    localparam logic [PERIOD_W:0] LANES_X  = (PERIOD_W+1)'(LANES);

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic [PERIOD_W:0]   raw;
        logic [PERIOD_W:0]   at;
        logic                exp_mark;
        logic [LANE_W-1:0]   exp_lane;

        assign raw      = {1'b0, pos} + (PERIOD_W+1)'(g);
        assign at       = (raw >= PERIOD_X) ? raw - PERIOD_X : raw;
        assign exp_mark = (at < LANES_X);
        assign exp_lane = at[LANE_W-1:0];
        assign row_err[g] = (mark[g] != exp_mark) ||
                            (mark[g] && (lane[g*LANE_W +: LANE_W] != exp_lane));
    end

endmodule

// File: rtl/lam_pos_tracker.sv
module lam_pos_tracker #(
    parameter int LANES    = 4,
    parameter int PERIOD   = 65536,
    parameter int PERIOD_W = 17,
    parameter int LANE_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [lam_pkg::ROWS-1:0]        mark,
    input  logic [lam_pkg::ROWS*LANE_W-1:0] lane,
    output logic                            locked,
    output logic [PERIOD_W-1:0]             pos
);
    import lam_pkg::*;

    localparam logic [PERIOD_W:0] PERIOD_X = (PERIOD_W+1)'(PERIOD);
    localparam logic [PERIOD_W:0] ROWS_X   = (PERIOD_W+1)'(ROWS);

    typedef struct packed {
        logic                locked;
        logic [PERIOD_W-1:0] pos;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [PERIOD_W:0] step;
    logic              found;

    always_comb begin
        trk_d = trk_q;
        found = 1'b0;
        step  = {1'b0, trk_q.pos} + ROWS_X;
        if (step >= PERIOD_X) begin
            step = step - PERIOD_X;
        end
        if (in_valid) begin
            if (trk_q.locked) begin
                trk_d.pos = step[PERIOD_W-1:0];
            end else begin
                for (int r = 0; r < ROWS; r++) begin
                    if (!found && mark[r] && (lane[r*LANE_W +: LANE_W] == '0)) begin
                        found        = 1'b1;
                        trk_d.locked = 1'b1;
                        trk_d.pos    = PERIOD_W'(ROWS - r);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign locked = trk_q.locked;
    assign pos    = trk_q.pos;

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ({1'b0, pos} < PERIOD_X));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pos) && $stable(locked)));

endmodule

// File: rtl/lam_seq_check.sv
module lam_seq_check #(
    parameter int LANES = 4,
    parameter int GAP   = 16383,
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      in_valid,
    input  logic [lam_pkg::ROWS-1:0]                  in_mark,
    input  logic [lam_pkg::ROWS*LANE_W-1:0]           in_lane,
    input  logic [lam_pkg::ROWS*lam_pkg::BLK_W-1:0]   in_blk,
    output logic                                      out_valid,
    output logic                                      out_fail,
    output logic [lam_pkg::ROWS*lam_pkg::BLK_W-1:0]   out_blk
);
    import lam_pkg::*;

    localparam int PERIOD   = (GAP + 1) * LANES;
    localparam int PERIOD_W = $clog2(PERIOD + 1);
    localparam logic [ROWS*BLK_W-1:0] ERR_GROUP = {ROWS{err_block()}};

    typedef struct packed {
        logic                  valid;
        logic                  fail;
        logic [ROWS*BLK_W-1:0] blk;
    } out_t;

    logic                locked;
    logic [PERIOD_W-1:0] pos;
    logic [ROWS-1:0]     row_err;
    out_t                o_d, o_q;

    lam_pos_tracker #(
        .LANES(LANES), .PERIOD(PERIOD), .PERIOD_W(PERIOD_W), .LANE_W(LANE_W)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .mark(in_mark), .lane(in_lane), .locked(locked), .pos(pos)
    );

    lam_row_check #(
        .LANES(LANES), .PERIOD(PERIOD), .PERIOD_W(PERIOD_W), .LANE_W(LANE_W)
    ) u_rows (
        .pos(pos), .mark(in_mark), .lane(in_lane), .row_err(row_err)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = in_valid;
        o_d.fail  = in_valid && locked && (|row_err);
        o_d.blk   = o_d.fail ? ERR_GROUP : in_blk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_fail  = o_q.fail;
    assign out_blk   = o_q.blk;

    assert_valid_lat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_unlocked_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !locked) |=> !out_fail);

    assert_err_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fail |-> (out_blk == ERR_GROUP));

endmodule

// File: tb/lam_seq_check_tb.sv
module lam_seq_check_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 5;
    localparam int GAP    = 7;
    localparam int ROWS   = 8;
    localparam int BLK_W  = 66;
    localparam int LANE_W = 3;
    localparam int PERIOD = (GAP + 1) * LANES;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic [ROWS-1:0]         in_mark = '0;
    logic [ROWS*LANE_W-1:0]  in_lane = '0;
    logic [ROWS*BLK_W-1:0]   in_blk = '0;
    logic                    out_valid;
    logic                    out_fail;
    logic [ROWS*BLK_W-1:0]   out_blk;

    int checks = 0;
    int failures = 0;

    // model state
    bit m_locked = 0;
    int m_pos = 0;
    int t = 0;
    bit q_v[$];
    bit q_f[$];
    logic [ROWS*BLK_W-1:0] q_b[$];
    string q_tag[$];

    logic [ROWS-1:0]        g_mark;
    logic [ROWS*LANE_W-1:0] g_lane;
    logic [ROWS*BLK_W-1:0]  g_blk;

    lam_seq_check #(.LANES(LANES), .GAP(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mark(in_mark),
        .in_lane(in_lane), .in_blk(in_blk), .out_valid(out_valid),
        .out_fail(out_fail), .out_blk(out_blk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [BLK_W-1:0] ref_err();
        logic [BLK_W-1:0] e;
        e = '0;
        e[1:0] = 2'b01;
        e[9:2] = 8'h1E;
        for (int k = 0; k < 8; k++) e[10 + 7*k +: 7] = 7'h1E;
        return e;
    endfunction

    function automatic int pmod(int a);
        return ((a % PERIOD) + PERIOD) % PERIOD;
    endfunction

    task automatic chk(input string tag, input bit ok, input logic [ROWS*BLK_W-1:0] act,
                       input logic [ROWS*BLK_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build_clean();
        for (int i = 0; i < ROWS; i++) begin
            int p;
            logic [95:0] r;
            p = pmod(t + i);
            g_mark[i] = (p < LANES);
            g_lane[i*LANE_W +: LANE_W] = (p < LANES) ? LANE_W'(p) : '0;
            r = {$urandom(), $urandom(), $urandom()};
            g_blk[i*BLK_W +: BLK_W] = r[BLK_W-1:0];
        end
    endtask

    // behavioural reference: expected fail for a valid group
    function automatic bit model_group();
        bit f;
        f = 0;
        if (!m_locked) begin
            for (int r = 0; r < ROWS; r++) begin
                if (!m_locked && g_mark[r] && g_lane[r*LANE_W +: LANE_W] == 0) begin
                    m_locked = 1;
                    m_pos = ROWS - r;
                end
            end
        end else begin
            for (int i = 0; i < ROWS; i++) begin
                int p;
                bit em;
                p = (m_pos + i) % PERIOD;
                em = (p < LANES);
                if (g_mark[i] != em) f = 1;
                if (g_mark[i] && int'(g_lane[i*LANE_W +: LANE_W]) != p) f = 1;
            end
            m_pos = (m_pos + ROWS) % PERIOD;
        end
        return f;
    endfunction

    task automatic send(input bit valid, input string tag);
        bit f;
        bit ev, ef;
        logic [ROWS*BLK_W-1:0] eb;
        string et;
        f = valid ? model_group() : 1'b0;
        q_v.push_back(valid);
        q_f.push_back(f);
        q_b.push_back(f ? {ROWS{ref_err()}} : g_blk);
        q_tag.push_back(tag);
        in_valid = valid;
        in_mark  = g_mark;
        in_lane  = g_lane;
        in_blk   = g_blk;
        if (valid) t += ROWS;
        @(negedge clk);
        ev = q_v.pop_front();
        ef = q_f.pop_front();
        eb = q_b.pop_front();
        et = q_tag.pop_front();
        chk({"R9 valid ", et}, out_valid == ev, ROWS*BLK_W'(out_valid), ROWS*BLK_W'(ev));
        if (ev) begin
            chk({et, " fail flag"}, out_fail == ef, ROWS*BLK_W'(out_fail), ROWS*BLK_W'(ef));
            chk(ef ? {et, " R8 blocks"} : {et, " R9 blocks"}, out_blk == eb, out_blk, eb);
        end
    endtask

    task automatic send_clean(input string tag);
        build_clean();
        send(1'b1, tag);
    endtask

    task automatic skip_to_marker_group(input string tag);
        while (pmod(t) != PERIOD - 3) send_clean(tag);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        g_mark = '0; g_lane = '0; g_blk = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", out_valid == 1'b0, ROWS*BLK_W'(out_valid), '0);
        chk("R1 reset fail", out_fail == 1'b0, ROWS*BLK_W'(out_fail), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset valid", out_valid == 1'b0, ROWS*BLK_W'(out_valid), '0);
        chk("R1 after reset fail", out_fail == 1'b0, ROWS*BLK_W'(out_fail), '0);

        // R2: stray non-zero-lane markers before lock
        for (int k = 0; k < 3; k++) begin
            build_clean();
            g_mark = 8'b0010_0100;
            g_lane = '0;
            g_lane[2*LANE_W +: LANE_W] = 3'd2;
            g_lane[5*LANE_W +: LANE_W] = 3'd3;
            send(1'b1, "R2 prelock");
        end
        send(1'b0, "R10 idle prelock");

        // R3: lane-0 marker at row 3
        t = -3;
        send_clean("R3 lock group");
        send_clean("R3 after lock");
        send_clean("R3 after lock");

        // R4 / R10: clean stream across periods with idles
        for (int k = 0; k < 15; k++) begin
            send_clean("R4 clean");
            if (k % 3 == 0) send(1'b0, "R10 idle");
        end

        // R5: missing lane-0 marker
        skip_to_marker_group("R4 clean");
        build_clean();
        g_mark[3] = 1'b0;
        send(1'b1, "R5 missing");

        skip_to_marker_group("R11 after fault");
        send_clean("R11 marker group after fault");

        // R6: extra marker in a non-marker group
        build_clean();
        g_mark[2] = 1'b1;
        g_lane[2*LANE_W +: LANE_W] = 3'd1;
        send(1'b1, "R6 unexpected");

        // R7: wrong lane on row 4 (expects lane 1)
        skip_to_marker_group("R11 after fault");
        build_clean();
        g_lane[4*LANE_W +: LANE_W] = 3'd3;
        send(1'b1, "R7 wrong lane");

        for (int k = 0; k < 12; k++) send_clean("R11 recover");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule